// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block copies a run of words between a single attached device and system memory without the processor touching each word. Software first sets up four values through a small register port: the transfer direction, an identifier for the device, the first memory address and the number of words. Writing a nonzero word count while the engine is idle starts the run.

For every word the engine waits until the device signals it is ready. It then raises a bus request and, in the one cycle in which the grant is present, moves that word straight between itself and memory, so the word crosses the system bus only once. It then releases the bus at once. The processor is never interrupted during these stolen cycles. It only waits for its own next bus access. When the last word has moved, the engine stops, shows done in its status and holds an interrupt until software writes a new count.

Top module: `cs_dma`

## Requirements
- R1: After synchronous reset, `bus_req`, `bus_en`, `dev_ack` and `irq` are low, and every register reads zero.
- R2: Register map on `cfg_sel`: 0 is control/status, 1 is device identifier, 2 is memory address and 3 is word count. In the control/status register, bit 0 is the direction (0 means device to memory, 1 means memory to device), bit 1 reads busy and bit 2 reads done. The device identifier appears on `dev_id`. Reads return the programmed or current values.
- R3: Each grant carries exactly one word. `bus_en` is high for a single cycle per request, and `bus_req` is low in the cycle that follows the transfer.
- R4: A request is raised only after `dev_ready` has been seen in a waiting state. It is held until granted, and no strobe is driven without a grant.
- R5: Word k of a run uses address start+k, modulo 2^AW, so the address wraps from all ones to zero. The address register ends at start+count, and the count register ends at zero.
- R6: In device-to-memory runs, `bus_we` is high and `bus_wdata` carries the word captured at `dev_ready`. In memory-to-device runs, `bus_we` is low and the memory word appears on `dev_wdata`, with a one-cycle `dev_ack` in the cycle after the transfer.
- R7: After the last word, `irq` and the done bit are high and stay high until a count write. No further request is made, even if `dev_ready` pulses.
- R8: Register writes made while busy are ignored, whatever the register.
- R9: Writing a count of zero while idle clears done and `irq` but starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for `cfg_sel` |
| irq | output | 1 | Completion interrupt |
| dev_ready | input | 1 | Device ready for one word |
| dev_rdata | input | DW | Word offered by the device |
| dev_wdata | output | DW | Word delivered to the device |
| dev_ack | output | 1 | Word delivered / taken pulse |
| dev_id | output | DEVW | Programmed device identifier |
| dev_dir | output | 1 | Programmed direction |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_en | output | 1 | Bus cycle strobe |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |

## Verification
The bench builds the engine with a 16-bit data path, an 8-bit address and a 6-bit count. The narrow address lets a short run that starts at 0xFE cross the wrap to zero. The bench's arbiter can delay a grant by a chosen number of cycles or withhold it altogether. This exercises the case where a request is held while no grant arrives, and the case where a grant arrives after a delay.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DEV   = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2
    } seq_state_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } xfer_dir_e;

    localparam int CTRL_DIR_BIT  = 0;
    localparam int STAT_BUSY_BIT = 1;
    localparam int STAT_DONE_BIT = 2;

    function automatic logic writes_memory(input xfer_dir_e d);
        return d == DIR_DEV2MEM;
    endfunction

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DEVW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic            busy,
    input  logic            step,
    output xfer_dir_e       dir,
    output logic [DEVW-1:0] dev_id,
    output logic [AW-1:0]   cur_addr,
    output logic            cnt_last,
    output logic            start,
    output logic            done
);

    logic [CW-1:0] cur_cnt;
    logic          wr_ok;
    reg_sel_e      sel;

    assign sel      = reg_sel_e'(cfg_sel);
    assign wr_ok    = cfg_wr && !busy;
    assign start    = wr_ok && (sel == SEL_COUNT) && (cfg_wdata[CW-1:0] != '0);
    assign cnt_last = (cur_cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dir      <= DIR_DEV2MEM;
            dev_id   <= '0;
            cur_addr <= '0;
            cur_cnt  <= '0;
            done     <= 1'b0;
        end else if (wr_ok) begin
            case (sel)
                SEL_CTRL:  dir      <= xfer_dir_e'(cfg_wdata[CTRL_DIR_BIT]);
                SEL_DEV:   dev_id   <= cfg_wdata[DEVW-1:0];
                SEL_ADDR:  cur_addr <= cfg_wdata[AW-1:0];
                SEL_COUNT: begin
                    cur_cnt <= cfg_wdata[CW-1:0];
                    done    <= 1'b0;
                end
                default: ;
            endcase
        end else if (step) begin
            cur_addr <= cur_addr + AW'(1);
            cur_cnt  <= cur_cnt - CW'(1);
            if (cnt_last) begin
                done <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                cfg_rdata[CTRL_DIR_BIT]  = dir;
                cfg_rdata[STAT_BUSY_BIT] = busy;
                cfg_rdata[STAT_DONE_BIT] = done;
            end
            SEL_DEV:   cfg_rdata[DEVW-1:0] = dev_id;
            SEL_ADDR:  cfg_rdata[AW-1:0]   = cur_addr;
            SEL_COUNT: cfg_rdata[CW-1:0]   = cur_cnt;
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
    import cs_dma_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  xfer_dir_e     dir,
    input  logic          cnt_last,
    input  logic          dev_ready,
    input  logic [DW-1:0] dev_rdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          step,
    output logic          bus_req,
    output logic [DW-1:0] word_q,
    output logic          dev_ack
);

    seq_state_e state, nxt;

    assign busy    = (state != ST_IDLE);
    assign bus_req = (state == ST_REQ);
    assign step    = (state == ST_REQ) && bus_gnt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (start)     nxt = ST_WAIT;
            ST_WAIT: if (dev_ready) nxt = ST_REQ;
            ST_REQ:  if (bus_gnt)   nxt = cnt_last ? ST_IDLE : ST_WAIT;
            default:                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            word_q  <= '0;
            dev_ack <= 1'b0;
        end else begin
            state   <= nxt;
            dev_ack <= step && !writes_memory(dir);
            if ((state == ST_WAIT) && dev_ready && writes_memory(dir)) begin
                word_q <= dev_rdata;
            end else if (step && !writes_memory(dir)) begin
                word_q <= bus_rdata;
            end
        end
    end

endmodule

// File: rtl/cs_dma.sv
module cs_dma
    import cs_dma_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DEVW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [1:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    output logic            irq,
    input  logic            dev_ready,
    input  logic [DW-1:0]   dev_rdata,
    output logic [DW-1:0]   dev_wdata,
    output logic            dev_ack,
    output logic [DEVW-1:0] dev_id,
    output logic            dev_dir,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            bus_en,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata
);

    xfer_dir_e     dir;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] word_q;
    logic          busy, step, start, cnt_last, done;

    cs_dma_regs #(.DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .step      (step),
        .dir       (dir),
        .dev_id    (dev_id),
        .cur_addr  (cur_addr),
        .cnt_last  (cnt_last),
        .start     (start),
        .done      (done)
    );

    cs_dma_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dir       (dir),
        .cnt_last  (cnt_last),
        .dev_ready (dev_ready),
        .dev_rdata (dev_rdata),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .step      (step),
        .bus_req   (bus_req),
        .word_q    (word_q),
        .dev_ack   (dev_ack)
    );

    assign irq       = done;
    assign dev_dir   = dir;
    assign dev_wdata = word_q;
    assign bus_en    = step;
    assign bus_we    = step && writes_memory(dir);
    assign bus_addr  = step ? cur_addr : '0;
    assign bus_wdata = (step && writes_memory(dir)) ? word_q : '0;

endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk
    import cs_dma_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic [1:0]    cfg_sel,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_en,
    input logic [AW-1:0] bus_addr,
    input logic          irq
);

    logic [AW-1:0] last_addr;
    logic          chain_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_vld <= 1'b0;
            last_addr <= '0;
        end else if (cfg_wr && (cfg_sel == SEL_ADDR)) begin
            chain_vld <= 1'b0;
        end else if (bus_en) begin
            chain_vld <= 1'b1;
            last_addr <= bus_addr;
        end
    end

    p_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> (!bus_en && !bus_req));

    p_req_held_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> bus_req);

    p_strobe_granted_r4: assert property (@(posedge clk) disable iff (rst)
        bus_en |-> (bus_gnt && bus_req));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_en && chain_vld) |-> (bus_addr == AW'(last_addr + AW'(1))));

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !(cfg_wr && (cfg_sel == SEL_COUNT))) |=> irq);

    p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> !bus_req);

endmodule

bind cs_dma cs_dma_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_en   (bus_en),
    .bus_addr (bus_addr),
    .irq      (irq)
);

// File: tb/cs_dma_tb.sv
module cs_dma_tb;

    localparam int DW = 16, AW = 8, CW = 6, DEVW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [1:0]      cfg_sel = '0;
    logic [DW-1:0]   cfg_wdata = '0;
    logic [DW-1:0]   cfg_rdata;
    logic            irq;
    logic            dev_ready = 1'b0;
    logic [DW-1:0]   dev_rdata = '0;
    logic [DW-1:0]   dev_wdata;
    logic            dev_ack;
    logic [DEVW-1:0] dev_id;
    logic            dev_dir;
    logic            bus_req;
    logic            bus_gnt = 1'b0;
    logic            bus_en;
    logic            bus_we;
    logic [AW-1:0]   bus_addr;
    logic [DW-1:0]   bus_wdata;
    logic [DW-1:0]   bus_rdata;

    logic [DW-1:0] mem  [0:255];
    logic [DW-1:0] acks [0:63];
    int checks = 0, errors = 0;
    int strobes = 0, req_rises = 0, double_en = 0, we_err = 0, ack_n = 0;
    int gnt_lat = 0, req_age = 0;
    bit gnt_en = 1'b1, exp_we = 1'b1, prev_en = 1'b0, prev_req = 1'b0;

    always #5 clk = ~clk;

    cs_dma #(.DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .dev_ready(dev_ready), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_id(dev_id), .dev_dir(dev_dir),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    assign bus_rdata = mem[bus_addr];

    // memory, device-side capture and bus monitors
    always @(posedge clk) begin
        if (!rst) begin
            if (bus_en) begin
                strobes <= strobes + 1;
                if (bus_we) mem[bus_addr] <= bus_wdata;
                if (bus_we !== exp_we) we_err <= we_err + 1;
            end
            if (bus_en && prev_en) double_en <= double_en + 1;
            if (bus_req && !prev_req) req_rises <= req_rises + 1;
            if (dev_ack) begin
                acks[ack_n] <= dev_wdata;
                ack_n <= ack_n + 1;
            end
        end
        prev_en  <= bus_en;
        prev_req <= bus_req;
    end

    // arbiter with configurable latency
    always @(negedge clk) begin
        if (bus_req && gnt_en) begin
            if (req_age >= gnt_lat) bus_gnt <= 1'b1;
            req_age <= req_age + 1;
        end else begin
            bus_gnt <= 1'b0;
            req_age <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [DW-1:0] v);
        @(negedge clk);
        cfg_sel = s;
        #1;
        v = cfg_rdata;
    endtask

    task automatic prog(input logic d, input logic [DEVW-1:0] id,
                        input logic [AW-1:0] a, input logic [CW-1:0] n);
        wr(2'd0, DW'(d));
        wr(2'd1, DW'(id));
        wr(2'd2, DW'(a));
        wr(2'd3, DW'(n));
    endtask

    task automatic send_word(input logic [DW-1:0] v);
        int s0;
        s0 = strobes;
        @(negedge clk);
        dev_rdata = v; dev_ready = 1'b1;
        @(negedge clk);
        dev_ready = 1'b0;
        while (strobes == s0) @(negedge clk);
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        dev_ready = 1'b1;
        @(negedge clk);
        dev_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_req == 0 && bus_en == 0, "R1", "bus idle after reset", bus_req, 0);
        chk(irq == 0 && dev_ack == 0, "R1", "irq/ack low after reset", irq, 0);
        rd(2'd0, v); chk(v == 0, "R1", "status after reset", v, 0);
        rd(2'd3, v); chk(v == 0, "R1", "count after reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1", "address after reset", v, 0);
    endtask

    task automatic t_dev2mem();
        logic [DW-1:0] v;
        int s0, r0;
        gnt_lat = 0; exp_we = 1'b1;
        s0 = strobes; r0 = req_rises;
        prog(1'b0, 4'd5, 8'h10, 6'd3);
        chk(dev_id == 5, "R2", "device id output", dev_id, 5);
        rd(2'd0, v); chk(v == 16'h2, "R2", "status busy dir0", v, 2);
        send_word(16'hA1A1);
        send_word(16'hB2B2);
        send_word(16'hC3C3);
        chk(mem[8'h10] == 16'hA1A1, "R6", "word0 to memory", mem[8'h10], 16'hA1A1);
        chk(mem[8'h11] == 16'hB2B2, "R6", "word1 to memory", mem[8'h11], 16'hB2B2);
        chk(mem[8'h12] == 16'hC3C3, "R6", "word2 to memory", mem[8'h12], 16'hC3C3);
        chk(we_err == 0, "R6", "write enable for dev-to-mem", we_err, 0);
        chk(irq == 1, "R7", "irq after last word", irq, 1);
        rd(2'd0, v); chk(v == 16'h4, "R7", "status done", v, 4);
        rd(2'd3, v); chk(v == 0, "R5", "count ends at zero", v, 0);
        rd(2'd2, v); chk(v == 16'h13, "R5", "address ends at start+count", v, 16'h13);
        chk(strobes - s0 == 3, "R3", "one strobe per word", strobes - s0, 3);
        chk(req_rises - r0 == 3, "R3", "one request per word", req_rises - r0, 3);
        chk(double_en == 0, "R3", "no back-to-back strobes", double_en, 0);
    endtask

    task automatic t_mem2dev();
        logic [DW-1:0] v;
        int a0;
        gnt_lat = 3; exp_we = 1'b0;
        for (int i = 0; i < 4; i++) mem[8'h40 + i] = 16'h1000 + DW'(i * 16'h111);
        a0 = ack_n;
        prog(1'b1, 4'd9, 8'h40, 6'd4);
        chk(dev_dir == 1, "R2", "direction output", dev_dir, 1);
        for (int i = 0; i < 4; i++) send_word(16'hDEAD);
        @(negedge clk);
        chk(ack_n - a0 == 4, "R6", "ack pulses", ack_n - a0, 4);
        for (int i = 0; i < 4; i++)
            chk(acks[a0 + i] == 16'h1000 + DW'(i * 16'h111), "R6", "word to device",
                acks[a0 + i], 16'h1000 + i * 16'h111);
        chk(we_err == 0, "R6", "no write enable for mem-to-dev", we_err, 0);
        chk(irq == 1, "R7", "irq after mem-to-dev", irq, 1);
        rd(2'd2, v); chk(v == 16'h44, "R5", "address after mem-to-dev", v, 16'h44);
        chk(double_en == 0, "R3", "single strobes with delayed grant", double_en, 0);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] v;
        gnt_lat = 1; exp_we = 1'b1;
        prog(1'b0, 4'd2, 8'hFE, 6'd3);
        send_word(16'h0F0E);
        send_word(16'h0F0F);
        send_word(16'h0F00);
        chk(mem[8'hFE] == 16'h0F0E, "R5", "wrap word at FE", mem[8'hFE], 16'h0F0E);
        chk(mem[8'hFF] == 16'h0F0F, "R5", "wrap word at FF", mem[8'hFF], 16'h0F0F);
        chk(mem[8'h00] == 16'h0F00, "R5", "wrap word at 00", mem[8'h00], 16'h0F00);
        rd(2'd2, v); chk(v == 16'h01, "R5", "address after wrap", v, 1);
    endtask

    task automatic t_busy();
        logic [DW-1:0] v;
        gnt_lat = 0; exp_we = 1'b1;
        mem[8'h20] = 16'h5555;
        prog(1'b0, 4'd3, 8'h80, 6'd2);
        wr(2'd2, 16'h20);
        wr(2'd3, 16'd9);
        wr(2'd1, 16'd7);
        wr(2'd0, 16'd1);
        rd(2'd2, v); chk(v == 16'h80, "R8", "address write ignored", v, 16'h80);
        rd(2'd3, v); chk(v == 16'd2, "R8", "count write ignored", v, 2);
        chk(dev_id == 3, "R8", "device id write ignored", dev_id, 3);
        rd(2'd0, v); chk(v == 16'h2, "R8", "direction write ignored", v, 2);
        send_word(16'h8080);
        send_word(16'h8181);
        chk(mem[8'h80] == 16'h8080, "R8", "run used original address", mem[8'h80], 16'h8080);
        chk(mem[8'h81] == 16'h8181, "R8", "second word", mem[8'h81], 16'h8181);
        chk(mem[8'h20] == 16'h5555, "R8", "ignored address untouched", mem[8'h20], 16'h5555);
    endtask

    task automatic t_gate();
        int s0;
        gnt_lat = 0; exp_we = 1'b1;
        prog(1'b0, 4'd1, 8'h30, 6'd1);
        s0 = strobes;
        repeat (8) @(negedge clk);
        chk(bus_req == 0 && strobes == s0, "R4", "no request before ready", bus_req, 0);
        gnt_en = 1'b0;
        @(negedge clk);
        dev_rdata = 16'h7777; dev_ready = 1'b1;
        @(negedge clk);
        dev_ready = 1'b0;
        repeat (6) @(negedge clk);
        chk(bus_req == 1, "R4", "request held without grant", bus_req, 1);
        chk(strobes == s0, "R4", "no strobe without grant", strobes - s0, 0);
        gnt_en = 1'b1;
        while (strobes == s0) @(negedge clk);
        chk(mem[8'h30] == 16'h7777, "R4", "word moved after grant", mem[8'h30], 16'h7777);
        chk(irq == 1, "R7", "irq after single-word run", irq, 1);
    endtask

    task automatic t_sticky();
        logic [DW-1:0] v;
        int s0;
        s0 = strobes;
        repeat (15) @(negedge clk);
        pulse_ready();
        repeat (5) @(negedge clk);
        chk(irq == 1, "R7", "irq held until count write", irq, 1);
        chk(bus_req == 0 && strobes == s0, "R7", "ready ignored when done", strobes - s0, 0);
        wr(2'd3, 16'd0);
        chk(irq == 0, "R9", "zero count clears irq", irq, 1'b0);
        rd(2'd0, v); chk(v == 0, "R9", "zero count: not busy, not done", v, 0);
        pulse_ready();
        repeat (5) @(negedge clk);
        chk(bus_req == 0 && strobes == s0, "R9", "zero count starts nothing", strobes - s0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        t_reset();
        t_dev2mem();
        t_mem2dev();
        t_wrap();
        t_busy();
        t_gate();
        t_sticky();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule